// File: doc/BRIEF.md
# Selectable-Code Concurrent Error Checker

This block checks the output word of a combinational data path while the data path runs. A separate predictor, outside this block, derives check bits from the data path inputs. The checker receives those predicted bits together with the actual output word. It derives the same check bits again from the output word and raises one error flag when the two sets disagree.

Three codes are available, chosen by a parameter:

- **Single parity:** one check bit.
- **Split parity:** two check bits, built from adjacent output pairs.
- **Duplication:** the predictor is a full second copy of the data path, so the check word is as wide as the output.

The block holds no state and needs no clock. The flag can therefore gate a register update in the same cycle.

The width of the predicted-bits port depends on the selected code:

| Code | Predicted-bit width |
|------|---------------------|
| Single parity | 1 |
| Split parity | 2 |
| Duplication | N_OUT |

Split parity needs an even output width. An odd output width in that mode stops elaboration with an error message.

Top module: `scc_checker`

## Requirements
- R1: With the parity code, the regenerated check bit is the XOR of all bits of `data_i`. The flag is 1 exactly when this bit differs from `pred_i[0]`.
- R2: With the split-parity code, `pred_i[0]` is compared against the XOR, over all pairs (`data_i[2k]`, `data_i[2k+1]`), of the AND of each pair.
- R3: With the split-parity code, `pred_i[1]` is compared against the XOR, over the same pairs, of the OR of each pair.
- R4: `err_o` is the OR of all per-bit mismatches between regenerated and predicted check bits. It is 0 whenever every check bit agrees, including the all-zero word.
- R5: With the duplication code, `pred_i` is N_OUT bits wide and is compared bit for bit with `data_i`. Any difference of one or more bits sets `err_o`; equal words clear it.
- R6: With the parity code, flipping an even number of output bits against a correct prediction leaves `err_o` at 0.
- R7: With the split-parity code, flipping any single output bit against a correct prediction sets `err_o`.
- R8: `err_o` follows a change on `data_i` or `pred_i` with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | N_OUT | Actual output word of the protected data path |
| pred_i | input | M (1, 2 or N_OUT by code) | Check bits from the external predictor |
| err_o | output | 1 | Mismatch flag, 1 on any disagreement |

## Verification
The block has no state, so there is no internal state that could go wrong. A fault in the generator or in the comparator shows at `err_o` within the same input change. It appears either as a missed mismatch or as a false alarm on a correctly predicted word.

For that reason, the checks pair correctly predicted words with injected output flips and corrupted predictions. They cover single flips at every bit position and even-count flips, which are the cases where the three codes differ.

// File: rtl/scc_pkg.sv
package scc_pkg;

  typedef enum logic [1:0] {
    CODE_PARITY = 2'd0,
    CODE_SPLIT  = 2'd1,
    CODE_DUP    = 2'd2
  } code_e;

  // Number of check bits carried for a given code and output width.
  function automatic int chk_width(code_e code, int n_out);
    case (code)
      CODE_PARITY: return 1;
      CODE_SPLIT:  return 2;
      default:     return n_out;
    endcase
  endfunction

endpackage

// File: rtl/scc_gen.sv
module scc_gen #(
  parameter int            N_OUT = 8,
  parameter scc_pkg::code_e MODE = scc_pkg::CODE_SPLIT,
  localparam int           M     = scc_pkg::chk_width(MODE, N_OUT)
) (
  input  logic [N_OUT-1:0] data_i,
  output logic [M-1:0]     chk_o
);

  if (MODE == scc_pkg::CODE_PARITY) begin : g_parity
    assign chk_o = ^data_i;
  end else if (MODE == scc_pkg::CODE_SPLIT) begin : g_split
    localparam int PAIRS = N_OUT / 2;

    logic [PAIRS-1:0] pair_and;
    logic [PAIRS-1:0] pair_or;

    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
      assign pair_and[k] = data_i[2*k] & data_i[2*k+1];
      assign pair_or[k]  = data_i[2*k] | data_i[2*k+1];
    end

    assign chk_o = {^pair_or, ^pair_and};
  end else begin : g_dup
    assign chk_o = data_i;
  end

endmodule

// File: rtl/scc_cmp.sv
module scc_cmp #(
  parameter int M = 2
) (
  input  logic [M-1:0] gen_i,
  input  logic [M-1:0] pred_i,
  output logic         err_o
);

  logic [M-1:0] diff;

  assign diff  = gen_i ^ pred_i;
  assign err_o = |diff;

endmodule

// File: rtl/scc_checker.sv
module scc_checker #(
  parameter int             N_OUT = 8,
  parameter scc_pkg::code_e MODE  = scc_pkg::CODE_SPLIT,
  localparam int            M     = scc_pkg::chk_width(MODE, N_OUT)
) (
  input  logic [N_OUT-1:0] data_i,
  input  logic [M-1:0]     pred_i,
  output logic             err_o
);

  if (MODE == scc_pkg::CODE_SPLIT && (N_OUT % 2) != 0) begin : g_bad_width
    $error("split-parity code needs an even output width");
  end

  logic [M-1:0] gen_chk;

  scc_gen #(
    .N_OUT(N_OUT),
    .MODE (MODE)
  ) u_gen (
    .data_i(data_i),
    .chk_o (gen_chk)
  );

  scc_cmp #(
    .M(M)
  ) u_cmp (
    .gen_i (gen_chk),
    .pred_i(pred_i),
    .err_o (err_o)
  );

endmodule

// File: rtl/scc_checker_chk.sv
module scc_checker_chk #(
  parameter int             N_OUT = 8,
  parameter scc_pkg::code_e MODE  = scc_pkg::CODE_SPLIT,
  localparam int            M     = scc_pkg::chk_width(MODE, N_OUT)
) (
  input logic [N_OUT-1:0] data_i,
  input logic [M-1:0]     pred_i,
  input logic [M-1:0]     gen_chk,
  input logic             err_o
);

  always_comb begin
    AST_ERR_MATCH: assert (err_o == (gen_chk != pred_i)); // R4

    if (MODE == scc_pkg::CODE_PARITY) begin
      AST_PAR_BIT: assert (err_o == ((^data_i) != pred_i[0])); // R1
    end

    if (MODE == scc_pkg::CODE_SPLIT && data_i == '0) begin
      AST_SPLIT_ZERO: assert (err_o == (pred_i != '0)); // R2
    end

    if (MODE == scc_pkg::CODE_SPLIT && data_i == '1) begin
      AST_SPLIT_ONES: assert (err_o == (pred_i[1] != pred_i[0] ||
                                        pred_i[0] != logic'((N_OUT / 2) % 2))); // R3
    end

    if (MODE == scc_pkg::CODE_DUP) begin
      AST_DUP_EQ: assert (err_o == (data_i != N_OUT'(pred_i))); // R5
    end
  end

endmodule

bind scc_checker scc_checker_chk #(
  .N_OUT(N_OUT),
  .MODE (MODE)
) u_chk (
  .data_i (data_i),
  .pred_i (pred_i),
  .gen_chk(gen_chk),
  .err_o  (err_o)
);

// File: tb/scc_checker_tb.sv
module scc_checker_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  typedef struct {
    int    which;
    logic  exp;
    string req;
  } item_t;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [N-1:0] d_spl, d_par, d_dup;
  logic [1:0]   p_spl;
  logic [0:0]   p_par;
  logic [N-1:0] p_dup;
  logic         e_spl, e_par, e_dup;

  scc_checker #(.N_OUT(N), .MODE(scc_pkg::CODE_SPLIT)) u_dut (
    .data_i(d_spl), .pred_i(p_spl), .err_o(e_spl));

  scc_checker #(.N_OUT(N), .MODE(scc_pkg::CODE_PARITY)) u_dut_par (
    .data_i(d_par), .pred_i(p_par), .err_o(e_par));

  scc_checker #(.N_OUT(N), .MODE(scc_pkg::CODE_DUP)) u_dut_dup (
    .data_i(d_dup), .pred_i(p_dup), .err_o(e_dup));

  item_t q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;

  function automatic logic gold_par(logic [N-1:0] d);
    logic r = 1'b0;
    for (int i = 0; i < N; i++) r = r ^ d[i];
    return r;
  endfunction

  function automatic logic [1:0] gold_split(logic [N-1:0] d);
    logic a = 1'b0;
    logic o = 1'b0;
    for (int k = 0; k < N / 2; k++) begin
      a = a ^ (d[2*k] & d[2*k+1]);
      o = o ^ (d[2*k] | d[2*k+1]);
    end
    return {o, a};
  endfunction

  // Driver: applies one vector to one instance and queues the expected flag.
  task automatic send(int which, logic [N-1:0] d, logic [N-1:0] p,
                      logic exp, string req);
    item_t it;
    @(posedge clk);
    case (which)
      0: begin d_spl = d; p_spl = p[1:0]; end
      1: begin d_par = d; p_par = p[0:0]; end
      default: begin d_dup = d; p_dup = p; end
    endcase
    it.which = which;
    it.exp   = exp;
    it.req   = req;
    q.push_back(it);
  endtask

  // Monitor: half a cycle later, with no clock edge in between (R8).
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic  act;
      it  = q.pop_front();
      act = (it.which == 0) ? e_spl : (it.which == 1) ? e_par : e_dup;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s unit %0d: err_o=%b expected %b",
                 it.req, it.which, act, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] pats [6];
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5;
    pats[3] = 8'h3C; pats[4] = 8'h81; pats[5] = 8'h6E;

    d_spl = '0; p_spl = '0;
    d_par = '0; p_par = '0;
    d_dup = '0; p_dup = '0;

    // R4: idle all-zero word on every code.
    send(0, 8'h00, 8'h00, 1'b0, "R4");
    send(1, 8'h00, 8'h00, 1'b0, "R4");
    send(2, 8'h00, 8'h00, 1'b0, "R4");

    for (int i = 0; i < 6; i++) begin
      logic [N-1:0] d;
      logic [1:0]   sp;
      d  = pats[i];
      sp = gold_split(d);
      // R1: correct and wrong parity predictions.
      send(1, d, {7'd0, gold_par(d)}, 1'b0, "R1");
      send(1, d, {7'd0, ~gold_par(d)}, 1'b1, "R1");
      // R2 / R3: correct split prediction, then each check bit corrupted.
      send(0, d, {6'd0, sp}, 1'b0, "R2");
      send(0, d, {6'd0, sp ^ 2'b01}, 1'b1, "R2");
      send(0, d, {6'd0, sp ^ 2'b10}, 1'b1, "R3");
      // R4: both split bits corrupted still gives a single flag.
      send(0, d, {6'd0, ~sp}, 1'b1, "R4");
      // R5: duplicate equal.
      send(2, d, d, 1'b0, "R5");
      for (int b = 0; b < N; b++) begin
        logic [N-1:0] f;
        f = d ^ (N'(1) << b);
        // R7: single-bit flip on split parity always flagged.
        send(0, f, {6'd0, sp}, 1'b1, "R7");
        // R1: single flip on parity flagged.
        send(1, f, {7'd0, gold_par(d)}, 1'b1, "R1");
        // R5: single-bit duplicate difference flagged.
        send(2, f, d, 1'b1, "R5");
        // R6: double flip invisible to parity.
        send(1, f ^ (N'(1) << ((b + 3) % N)), {7'd0, gold_par(d)}, 1'b0, "R6");
      end
      // R5: multi-bit difference.
      send(2, d ^ 8'hF0, d, 1'b1, "R5");
    end

    // R6: all bits flipped (even count).
    send(1, 8'hFF, 8'h00, 1'b0, "R6");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule